// File: doc/BRIEF.md
# DLL Sampling Phase Programming Sequencer

This block moves the output clock of a delay-locked loop to a requested sampling phase (0 to 15) without glitching the recovered clock. A single start pulse with a 4-bit phase runs a fixed handshake. The block first turns off the clock output and hands phase control to the external select path. It waits for the loop to confirm that the output is off. It then writes the phase in Gray code, turns the output back on and waits for the loop to confirm that. Finally it gives control back to the internal clock-data-recovery path.

Each confirmation wait is polled at a fixed spacing taken from a prescaler, with a bounded number of polls. If the confirmation never arrives, the sequence stops with a sticky error and the control bits keep their values. The DLL itself sits outside the block and returns the clock-output-enable state on a feedback input.

Top module: `dll_phase_seq`

## Requirements
- R1: While reset is held and just after it is released, every control output is 0, `phase_sel_o` is 0, and `busy_o`, `done_o` and `err_o` are 0.
- R2: A start accepted in idle changes the outputs in one clock edge: `cdr_en_o`=0, `ck_out_en_o`=0, `cdr_ext_en_o`=1, `dll_en_o`=1 and `busy_o`=1. `phase_sel_o` is unchanged at that edge.
- R3: `phase_sel_o` changes only in the cycle after a poll in which `ck_out_fb_i` was 0. With polls every `TICKS_PER_POLL` cycles after the start edge, it changes exactly one edge after the first such poll.
- R4: The value written to `phase_sel_o` is the Gray code of the requested phase, p XOR (p>>1). This gives phases 0..15 the codes 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R5: `ck_out_en_o` is set one edge after the phase write, and only then does the block wait for `ck_out_fb_i`=1.
- R6: On the first poll that sees `ck_out_fb_i`=1, one edge sets `cdr_en_o`=1 and clears `cdr_ext_en_o`. The same edge pulses `done_o` high for exactly one cycle and drops `busy_o`.
- R7: Polls occur every `TICKS_PER_POLL` cycles, and each wait allows at most `MAX_POLLS` of them. A wait that never succeeds ends `TICKS_PER_POLL*MAX_POLLS` edges after that wait began.
- R8: On timeout every control output and `phase_sel_o` keep their values, `busy_o` drops, `done_o` stays low, and `err_o` rises and holds until the next accepted start clears it.
- R9: A start while `busy_o` is 1 is ignored, and the running sequence completes with its original phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| phase_i | input | PHASE_W | Requested phase, binary |
| ck_out_fb_i | input | 1 | Clock-output-enable state returned by the DLL |
| cdr_en_o | output | 1 | Internal clock-data-recovery enable |
| cdr_ext_en_o | output | 1 | External phase select enable |
| dll_en_o | output | 1 | DLL enable |
| ck_out_en_o | output | 1 | DLL clock output enable |
| phase_sel_o | output | PHASE_W | Gray-coded phase select field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on success |
| err_o | output | 1 | Sticky timeout flag |

## Verification
A stuck state register shows at the ports within one poll period. If it skips the disable wait, the phase field changes before the feedback has fallen, a cycle count that the ordering test measures exactly. A wrong prescaler or poll counter moves the timeout edge away from `TICKS_PER_POLL*MAX_POLLS`. That error is visible as soon as `busy_o` drops. A wrong Gray mapping or a control bit left in the wrong state shows in the final outputs of every completed sequence, and the sweep over all sixteen phases covers this.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT_OFF,
    SEQ_WRITE,
    SEQ_ARM,
    SEQ_WAIT_ON
  } seq_state_e;

  typedef struct packed {
    logic cdr_en;
    logic cdr_ext;
    logic dll_en;
    logic ck_out;
  } dll_ctrl_t;

  function automatic logic [7:0] gray_to_bin(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dps_gray_enc.sv
module dps_gray_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_msb
      assign gray_o[i] = bin_i[i];
    end else begin : g_low
      assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
    end
  end
endmodule

// File: rtl/dps_poll_timer.sv
module dps_poll_timer #(
  parameter int TICKS_PER_POLL = 50,
  parameter int MAX_POLLS      = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic en_i,
  output logic poll_o,
  output logic last_o
);
  localparam int TW = (TICKS_PER_POLL > 1) ? $clog2(TICKS_PER_POLL) : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_POLL - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] polls_q;

  assign poll_o = en_i && (tick_q == TICK_LAST);
  assign last_o = (polls_q == POLL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      polls_q <= '0;
    end else if (restart_i) begin
      tick_q  <= '0;
      polls_q <= '0;
    end else if (en_i) begin
      if (tick_q == TICK_LAST) begin
        tick_q <= '0;
        if (polls_q != POLL_LAST) polls_q <= polls_q + PW'(1);
      end else begin
        tick_q <= tick_q + TW'(1);
      end
    end
  end

  // R7: the poll index never runs past the bound
  assert_poll_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(polls_q) < MAX_POLLS) && (int'(tick_q) < TICKS_PER_POLL));
endmodule

// File: rtl/dll_phase_seq.sv
module dll_phase_seq
  import dps_pkg::*;
#(
  parameter int PHASE_W        = 4,
  parameter int TICKS_PER_POLL = 50,
  parameter int MAX_POLLS      = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               ck_out_fb_i,
  output logic               cdr_en_o,
  output logic               cdr_ext_en_o,
  output logic               dll_en_o,
  output logic               ck_out_en_o,
  output logic [PHASE_W-1:0] phase_sel_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  seq_state_e         state_q;
  dll_ctrl_t          ctrl_q;
  logic [PHASE_W-1:0] phase_q, gray_w, sel_q;
  logic               done_q, err_q;
  logic               poll_w, last_w, restart_w, wait_w;

  assign restart_w = ((state_q == SEQ_IDLE) && start_i) || (state_q == SEQ_ARM);
  assign wait_w    = (state_q == SEQ_WAIT_OFF) || (state_q == SEQ_WAIT_ON);

  dps_poll_timer #(
    .TICKS_PER_POLL(TICKS_PER_POLL),
    .MAX_POLLS     (MAX_POLLS)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_w),
    .en_i     (wait_w),
    .poll_o   (poll_w),
    .last_o   (last_w)
  );

  dps_gray_enc #(.W(PHASE_W)) i_gray (
    .bin_i (phase_q),
    .gray_o(gray_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      ctrl_q  <= '0;
      phase_q <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          // off, external select, enabled: one update
          ctrl_q  <= '{cdr_en: 1'b0, cdr_ext: 1'b1, dll_en: 1'b1, ck_out: 1'b0};
          phase_q <= phase_i;
          err_q   <= 1'b0;
          state_q <= SEQ_WAIT_OFF;
        end
        SEQ_WAIT_OFF: if (poll_w) begin
          if (!ck_out_fb_i) begin
            state_q <= SEQ_WRITE;
          end else if (last_w) begin
            err_q   <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
        SEQ_WRITE: begin
          sel_q   <= gray_w;
          state_q <= SEQ_ARM;
        end
        SEQ_ARM: begin
          ctrl_q.ck_out <= 1'b1;
          state_q       <= SEQ_WAIT_ON;
        end
        SEQ_WAIT_ON: if (poll_w) begin
          if (ck_out_fb_i) begin
            ctrl_q.cdr_en  <= 1'b1;
            ctrl_q.cdr_ext <= 1'b0;
            done_q         <= 1'b1;
            state_q        <= SEQ_IDLE;
          end else if (last_w) begin
            err_q   <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cdr_en_o     = ctrl_q.cdr_en;
  assign cdr_ext_en_o = ctrl_q.cdr_ext;
  assign dll_en_o     = ctrl_q.dll_en;
  assign ck_out_en_o  = ctrl_q.ck_out;
  assign phase_sel_o  = sel_q;
  assign busy_o       = (state_q != SEQ_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;

  assert_start_update_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!cdr_en_o && !ck_out_en_o && cdr_ext_en_o && dll_en_o
                              && busy_o && $stable(phase_sel_o)));

  assert_phase_after_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_sel_o) |-> ($past(state_q) == SEQ_WRITE) && !ck_out_en_o);

  assert_gray_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (gray_to_bin(8'(phase_sel_o)) == 8'(phase_q)));

  assert_arm_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ck_out_en_o) |-> $stable(phase_sel_o) && !cdr_en_o && busy_o);

  assert_finish_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cdr_en_o && !cdr_ext_en_o && ck_out_en_o && !busy_o && !err_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_timeout_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && !done_o && $stable(cdr_en_o) && $stable(cdr_ext_en_o)
                     && $stable(dll_en_o) && $stable(ck_out_en_o) && $stable(phase_sel_o));

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o && !$rose(err_o)) |=> $stable(phase_q));
endmodule

// File: tb/test_dll_phase_seq.sv
`timescale 1ns/1ps
module test_dll_phase_seq;
  localparam int TK = 5;
  localparam int MP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] phase = '0;
  logic       fb;
  logic       cdr_en, cdr_ext, dll_en, ck_out, busy, done, err;
  logic [3:0] sel;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int mode = 0;   // 0 follow, 1 stuck high, 2 stuck low
  int lat = 2;
  int lcnt = 0;

  logic [3:0] gray_tab [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                                4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

  always #10 clk = ~clk;

  dll_phase_seq #(.PHASE_W(4), .TICKS_PER_POLL(TK), .MAX_POLLS(MP)) i_dll_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_i(phase),
    .ck_out_fb_i(fb), .cdr_en_o(cdr_en), .cdr_ext_en_o(cdr_ext), .dll_en_o(dll_en),
    .ck_out_en_o(ck_out), .phase_sel_o(sel), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // DLL model: feedback follows clock-out enable after lat mismatched cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb <= 1'b0; lcnt <= 0;
    end else if (mode == 1) fb <= 1'b1;
    else if (mode == 2) fb <= 1'b0;
    else if (ck_out != fb) begin
      if (lcnt >= lat - 1) begin fb <= ck_out; lcnt <= 0; end
      else lcnt <= lcnt + 1;
    end else lcnt <= 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL R7 watchdog expired: got %0d cycles, expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // pulse start at a negedge; n = edges after accept until busy drops
  task automatic run(input logic [3:0] ph, output int n);
    @(negedge clk); start = 1'b1; phase = ph;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk("R1 ctrl", {cdr_en, cdr_ext, dll_en, ck_out}, 4'b0000);
    chk("R1 sel", sel, 4'h0);
    chk("R1 flags", {busy, done, err}, 3'b000);
  endtask

  task automatic t_sweep();
    int n;
    mode = 0; lat = 2;
    for (int p = 0; p < 16; p++) begin
      run(4'(p), n);
      chk("R6 done pulse", {done, busy, err}, 3'b100);
      chk("R6 final ctrl", {cdr_en, cdr_ext, dll_en, ck_out}, 4'b1011);
      chk("R4 gray", sel, gray_tab[p]);
      @(negedge clk);
      chk("R6 done one cycle", done, 1'b0);
    end
  endtask

  task automatic t_order();
    int n = 0, n_sel = -1, n_ck = -1;
    logic [3:0] prev;
    mode = 0; lat = 12;
    prev = sel;
    @(negedge clk); start = 1'b1; phase = 4'd5;
    @(negedge clk); start = 1'b0;
    chk("R2 first update", {cdr_en, cdr_ext, dll_en, ck_out, busy}, 5'b01101);
    chk("R2 sel kept", sel, prev);
    while (busy && n < 1000) begin
      @(negedge clk); n++;
      if (n_sel < 0 && sel != prev) n_sel = n;
      if (n_ck < 0 && ck_out) n_ck = n;
    end
    // fb falls after edge 12; polls at 5,10,15 -> write at 16
    chk("R3 phase write edge", n_sel, 16);
    chk("R5 clock out edge", n_ck, 17);
    chk("R4 gray 5", sel, gray_tab[5]);
    chk("R6 completed", {cdr_en, cdr_ext, err}, 3'b100);
  endtask

  task automatic t_timeout_off();
    int n;
    logic [3:0] prev;
    prev = sel;
    mode = 1;
    run(4'd9, n);
    chk("R7 timeout edge", n, TK * MP);
    chk("R8 err set", {err, busy, done}, 3'b100);
    chk("R8 ctrl kept", {cdr_en, cdr_ext, dll_en, ck_out}, 4'b0110);
    chk("R8 sel kept", sel, prev);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", err, 1'b1);
  endtask

  task automatic t_clear_err();
    int n;
    mode = 0; lat = 1;
    @(negedge clk); start = 1'b1; phase = 4'd2;
    @(negedge clk); start = 1'b0;
    chk("R8 err cleared by start", err, 1'b0);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk("R8 recovery done", {done, sel}, {1'b1, gray_tab[2]});
  endtask

  task automatic t_timeout_on();
    int n;
    mode = 2;
    run(4'd11, n);
    chk("R7 second wait timeout", n, TK + 2 + TK * MP);
    chk("R8 ctrl kept on", {cdr_en, cdr_ext, dll_en, ck_out}, 4'b0111);
    chk("R8 phase written", sel, gray_tab[11]);
    chk("R8 flags", {err, busy, done}, 3'b100);
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    mode = 0; lat = 1;
    @(negedge clk); start = 1'b1; phase = 4'd3;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; phase = 4'd12;
    @(negedge clk); start = 1'b0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk("R9 original phase kept", sel, gray_tab[3]);
    chk("R9 completed", {done, err}, 2'b10);
    @(negedge clk);
    chk("R9 no restart", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_order();
    t_timeout_off();
    t_clear_err();
    t_timeout_on();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule